// File: doc/BRIEF.md
# Debug Serial Port Target Interface

This block is the target end of a full-duplex synchronous debug link whose clock is generated by an external host. The serial clock and data inputs are brought into the system clock domain through a synchronizer. Edges are detected there. Every transfer moves one 17-bit word in each direction. The top bit is a status/control flag and the lower 16 bits carry data. Each word the host sends is handed to the core as 16 data bits with a one-cycle valid pulse. The flag bit the host sends is discarded.

The core queues one response at a time through a valid/ready handshake. It gives a response kind and, for plain data, a 16-bit value. The block turns the kind into the 17-bit response code. If nothing is queued when a transfer starts, the block sends the "not ready" code by itself. The link only works while the freeze input is high. While freeze is low, the output pin carries an ordinary status signal and the serial logic stays idle.

Top module: `dbg_serial_target`

## Requirements
- R1: Bits arrive most significant first and are captured on rising serial clock edges. After a full word, `rx_word_o` holds the last 16 bits received. The first bit of the word (the status/control flag) has no effect on it. The value is held until the first rising edge of the next word.
- R2: After the 17th rising edge of a word, `rx_valid_o` is high for exactly one system clock, and the bit count starts again from zero for the next word.
- R3: While freeze is high, `pin_o` shows bit 16 of the outgoing word before the first rising edge. Each falling edge inside the word advances it to the next lower bit, no later than three system clocks after the falling edge reaches `sclk_i`.
- R4: Each response kind maps to a fixed 17-bit code. Kind 0 (data) sends {0, `rsp_data_i`}. Kind 1 (complete) sends {0, FFFF}. Kind 2 (not ready) sends {1, 0000}. Kind 3 (bus error) sends {1, 0001}. Kind 4 (illegal command) sends {1, FFFF}. Kinds 5 to 7 are sent as illegal command.
- R5: If no response had been loaded into the outgoing register by the first rising edge of a word, the target sends {1, 0000}. A response accepted later in that word is kept and sent in the next word.
- R6: `rsp_ready_o` is high while the response slot is empty. A response is accepted when `rsp_valid_i` and `rsp_ready_o` are both high. After that, ready stays low until the first rising edge of the word that carries the response.
- R7: While freeze is low, `pin_o` equals `norm_stat_i`, serial clock edges raise no `rx_valid_o`, and a partly received word is dropped, so the next word after freeze returns is received whole.
- R8: After the synchronous active-high reset, `rx_valid_o` is 0, `rx_word_o` is 0, `rsp_ready_o` is 1, and with freeze high `pin_o` shows 1, the top bit of the "not ready" code.
- R9: Words are received correctly when each serial clock phase lasts only one system clock (serial clock at half the system clock).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze_i | input | 1 | Debug freeze; enables the serial link |
| norm_stat_i | input | 1 | Normal status output used on the shared pin while not frozen |
| sclk_i | input | 1 | Serial clock from the host (asynchronous) |
| sdi_i | input | 1 | Serial data from the host (asynchronous) |
| pin_o | output | 1 | Shared pin: serial data out when frozen, else normal status |
| rx_word_o | output | 16 | Data field of the last received word |
| rx_valid_o | output | 1 | One-cycle pulse when a word has been received |
| rsp_valid_i | input | 1 | Core offers a response |
| rsp_kind_i | input | 3 | Response kind code (0 data, 1 complete, 2 not ready, 3 bus error, 4 illegal) |
| rsp_data_i | input | 16 | Data value for kind 0 |
| rsp_ready_o | output | 1 | Response slot is empty |

## Verification
A bit counter that is off by one moves the valid pulse to the wrong edge and shifts the received data field by one bit. The bench sees both on the first word after the fault. A wrong outgoing shift register or a wrong response encoding shows at `pin_o` at the next sampled bit. A pending flag that is never cleared, or is cleared at the wrong time, shows as a stuck `rsp_ready_o` or as a response sent one word too early or too late. Each of these faults shows up within a single 17-bit transfer.

// File: rtl/dbg_serial_pkg.sv
package dbg_serial_pkg;
    typedef enum logic [2:0] {
        RSP_DATA     = 3'd0,
        RSP_DONE     = 3'd1,
        RSP_NOTRDY   = 3'd2,
        RSP_BUSERR   = 3'd3,
        RSP_ILLEGAL  = 3'd4
    } rsp_kind_e;
endpackage

// File: rtl/dbg_sync.sv
module dbg_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], d_i[b]};
        end

        always_ff @(posedge clk) begin
            if (rst) chain_q <= '0;
            else     chain_q <= chain_d;
        end

        assign q_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/dbg_rsp_enc.sv
module dbg_rsp_enc
    import dbg_serial_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  rsp_kind_e         kind_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W:0]   word_o
);
    always_comb begin
        unique case (kind_i)
            RSP_DATA:    word_o = {1'b0, data_i};
            RSP_DONE:    word_o = {1'b0, {DATA_W{1'b1}}};
            RSP_NOTRDY:  word_o = {1'b1, {DATA_W{1'b0}}};
            RSP_BUSERR:  word_o = {1'b1, DATA_W'(1)};
            default:     word_o = {1'b1, {DATA_W{1'b1}}};
        endcase
    end
endmodule

// File: rtl/dbg_shift_engine.sv
module dbg_shift_engine #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              freeze_i,
    input  logic              sclk_s_i,
    input  logic              sdi_s_i,
    input  logic              load_i,
    input  logic [DATA_W:0]   load_word_i,
    output logic              pend_full_o,
    output logic              tx_bit_o,
    output logic [DATA_W-1:0] rx_word_o,
    output logic              rx_valid_o
);
    localparam int WORD_W = DATA_W + 1;
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
    localparam logic [WORD_W-1:0] NOTRDY_WORD = {1'b1, {DATA_W{1'b0}}};

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] rx_sh;
        logic [WORD_W-1:0] tx_sh;
        logic              tx_src;
        logic              pend_v;
        logic [WORD_W-1:0] pend_w;
        logic              rx_valid;
        logic              clk_prev;
    } eng_t;

    eng_t st_d, st_q;
    logic rise, fall;

    always_comb begin
        rise = sclk_s_i & ~st_q.clk_prev;
        fall = ~sclk_s_i & st_q.clk_prev;

        st_d          = st_q;
        st_d.rx_valid = 1'b0;
        st_d.clk_prev = sclk_s_i;

        if (load_i) begin
            st_d.pend_v = 1'b1;
            st_d.pend_w = load_word_i;
        end

        if (!freeze_i) begin
            st_d.cnt = '0;
        end else if (rise) begin
            st_d.rx_sh = {st_q.rx_sh[DATA_W-2:0], sdi_s_i};
            if (st_q.cnt == '0 && st_q.tx_src) st_d.pend_v = 1'b0;
            if (st_q.cnt == LAST_BIT) begin
                st_d.cnt      = '0;
                st_d.rx_valid = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (fall && st_q.cnt != '0) begin
            st_d.tx_sh = {st_q.tx_sh[WORD_W-2:0], 1'b0};
        end

        if (st_q.cnt == '0 && !(freeze_i && rise)) begin
            st_d.tx_sh  = st_q.pend_v ? st_q.pend_w : NOTRDY_WORD;
            st_d.tx_src = st_q.pend_v;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_q.tx_sh <= NOTRDY_WORD;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_full_o = st_q.pend_v;
    assign tx_bit_o    = st_q.tx_sh[WORD_W-1];
    assign rx_word_o   = st_q.rx_sh;
    assign rx_valid_o  = st_q.rx_valid;

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= LAST_BIT);
    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o);
    assert_no_valid_unfrozen_R7: assert property (@(posedge clk) disable iff (rst)
        !freeze_i |=> !rx_valid_o);
    assert_tx_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (freeze_i && st_q.cnt != '0 && !fall) |=> $stable(st_q.tx_sh));
endmodule

// File: rtl/dbg_serial_target.sv
module dbg_serial_target
    import dbg_serial_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              freeze_i,
    input  logic              norm_stat_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    output logic              pin_o,
    output logic [DATA_W-1:0] rx_word_o,
    output logic              rx_valid_o,
    input  logic              rsp_valid_i,
    input  logic [2:0]        rsp_kind_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    output logic              rsp_ready_o
);
    logic [1:0]      sync_q;
    logic [DATA_W:0] enc_word;
    logic            pend_full;
    logic            tx_bit;
    logic            load;

    dbg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({sclk_i, sdi_i}),
        .q_o (sync_q)
    );

    dbg_rsp_enc #(.DATA_W(DATA_W)) u_enc (
        .kind_i (rsp_kind_e'(rsp_kind_i)),
        .data_i (rsp_data_i),
        .word_o (enc_word)
    );

    assign rsp_ready_o = ~pend_full;
    assign load        = rsp_valid_i & rsp_ready_o;

    dbg_shift_engine #(.DATA_W(DATA_W)) u_engine (
        .clk         (clk),
        .rst         (rst),
        .freeze_i    (freeze_i),
        .sclk_s_i    (sync_q[1]),
        .sdi_s_i     (sync_q[0]),
        .load_i      (load),
        .load_word_i (enc_word),
        .pend_full_o (pend_full),
        .tx_bit_o    (tx_bit),
        .rx_word_o   (rx_word_o),
        .rx_valid_o  (rx_valid_o)
    );

    assign pin_o = freeze_i ? tx_bit : norm_stat_i;

    assert_accept_fills_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid_i && rsp_ready_o) |=> !rsp_ready_o);
endmodule

// File: tb/dbg_serial_target_bench.sv
module dbg_serial_target_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        freeze_i = 1'b1;
    logic        norm_stat_i = 1'b0;
    logic        sclk_i = 1'b0;
    logic        sdi_i = 1'b0;
    logic        pin_o;
    logic [15:0] rx_word_o;
    logic        rx_valid_o;
    logic        rsp_valid_i = 1'b0;
    logic [2:0]  rsp_kind_i = 3'd0;
    logic [15:0] rsp_data_i = 16'h0;
    logic        rsp_ready_o;

    int checks = 0;
    int errors = 0;
    int vcount = 0;
    logic [15:0] last_word = 16'h0;

    always #2 clk = ~clk;

    dbg_serial_target u_dbg_serial_target (
        .clk(clk), .rst(rst), .freeze_i(freeze_i), .norm_stat_i(norm_stat_i),
        .sclk_i(sclk_i), .sdi_i(sdi_i), .pin_o(pin_o), .rx_word_o(rx_word_o),
        .rx_valid_o(rx_valid_o), .rsp_valid_i(rsp_valid_i), .rsp_kind_i(rsp_kind_i),
        .rsp_data_i(rsp_data_i), .rsp_ready_o(rsp_ready_o)
    );

    always @(negedge clk) begin
        if (!rst && rx_valid_o) begin
            vcount++;
            last_word = rx_word_o;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic host_xfer(input logic [16:0] w, input int half, output logic [16:0] got);
        for (int i = 16; i >= 0; i--) begin
            @(negedge clk);
            sclk_i = 1'b0;
            sdi_i  = w[i];
            repeat (half) @(negedge clk);
            got[i] = pin_o;
            sclk_i = 1'b1;
            repeat (half - 1) @(negedge clk);
        end
        @(negedge clk);
        sclk_i = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic load_rsp(input logic [2:0] kind, input logic [15:0] data);
        @(negedge clk);
        rsp_valid_i = 1'b1;
        rsp_kind_i  = kind;
        rsp_data_i  = data;
        @(negedge clk);
        rsp_valid_i = 1'b0;
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(rx_valid_o == 1'b0, "R8 valid after reset", 32'(rx_valid_o), 32'h0);
        check(rx_word_o == 16'h0, "R8 word after reset", 32'(rx_word_o), 32'h0);
        check(rsp_ready_o == 1'b1, "R8 ready after reset", 32'(rsp_ready_o), 32'h1);
        check(pin_o == 1'b1, "R8 pin shows not-ready msb", 32'(pin_o), 32'h1);
    endtask

    task automatic test_idle_notready();
        logic [16:0] got;
        int v0 = vcount;
        host_xfer(17'h0A5C3, 4, got);
        check(got == 17'h10000, "R5 auto not-ready", 32'(got), 32'h10000);
        check(vcount == v0 + 1, "R2 one valid pulse", 32'(vcount - v0), 32'h1);
        check(last_word == 16'hA5C3, "R1 received data", 32'(last_word), 32'hA5C3);
    endtask

    task automatic test_encodings();
        logic [16:0] got;
        logic [16:0] exp_w [6] = '{17'h01234, 17'h0FFFF, 17'h10000, 17'h10001, 17'h1FFFF, 17'h1FFFF};
        logic [2:0]  kinds [6] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd7};
        for (int k = 0; k < 6; k++) begin
            load_rsp(kinds[k], 16'h1234);
            check(rsp_ready_o == 1'b0, "R6 ready low after accept", 32'(rsp_ready_o), 32'h0);
            repeat (2) @(negedge clk);
            check(pin_o == exp_w[k][16], "R3 first bit before clocking", 32'(pin_o), 32'(exp_w[k][16]));
            host_xfer(17'h00F0F, 4, got);
            check(got == exp_w[k], "R4 response encoding", 32'(got), 32'(exp_w[k]));
            check(rsp_ready_o == 1'b1, "R6 ready after send", 32'(rsp_ready_o), 32'h1);
        end
    endtask

    task automatic test_sc_ignored();
        logic [16:0] got;
        host_xfer(17'h15A5A, 4, got);
        check(last_word == 16'h5A5A, "R1 flag bit set ignored", 32'(last_word), 32'h5A5A);
        host_xfer(17'h0C3C3, 2, got);
        check(last_word == 16'hC3C3, "R1 flag bit clear", 32'(last_word), 32'hC3C3);
    endtask

    task automatic test_late_response();
        logic [16:0] got;
        fork
            host_xfer(17'h01111, 4, got);
            begin
                repeat (30) @(negedge clk);
                load_rsp(3'd0, 16'hBEEF);
            end
        join
        check(got == 17'h10000, "R5 late response not sent yet", 32'(got), 32'h10000);
        check(rsp_ready_o == 1'b0, "R6 late response still pending", 32'(rsp_ready_o), 32'h0);
        host_xfer(17'h02222, 4, got);
        check(got == 17'h0BEEF, "R5 late response in next word", 32'(got), 32'h0BEEF);
        check(rsp_ready_o == 1'b1, "R6 slot freed", 32'(rsp_ready_o), 32'h1);
    endtask

    task automatic test_freeze_off();
        logic [16:0] got;
        int v0;
        @(negedge clk);
        freeze_i = 1'b0;
        norm_stat_i = 1'b0;
        @(negedge clk);
        check(pin_o == 1'b0, "R7 pin follows status low", 32'(pin_o), 32'h0);
        norm_stat_i = 1'b1;
        @(negedge clk);
        check(pin_o == 1'b1, "R7 pin follows status high", 32'(pin_o), 32'h1);
        freeze_i = 1'b1;
        v0 = vcount;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); sdi_i = 1'b1; sclk_i = 1'b0;
            repeat (4) @(negedge clk); sclk_i = 1'b1;
            repeat (4) @(negedge clk);
        end
        @(negedge clk); sclk_i = 1'b0;
        repeat (6) @(negedge clk);
        freeze_i = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); sclk_i = 1'b1;
            repeat (3) @(negedge clk); sclk_i = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        check(vcount == v0, "R7 no valid while unfrozen", 32'(vcount - v0), 32'h0);
        freeze_i = 1'b1;
        repeat (4) @(negedge clk);
        host_xfer(17'h06789, 4, got);
        check(vcount == v0 + 1 && last_word == 16'h6789, "R7 partial word dropped",
              32'(last_word), 32'h6789);
    endtask

    task automatic test_fast();
        logic [16:0] got;
        int v0 = vcount;
        host_xfer(17'h09A3C, 1, got);
        check(last_word == 16'h9A3C, "R9 half-rate receive", 32'(last_word), 32'h9A3C);
        check(vcount == v0 + 1, "R9 R2 half-rate single pulse", 32'(vcount - v0), 32'h1);
    endtask

    initial begin
        test_reset();
        test_idle_notready();
        test_encodings();
        test_sc_ignored();
        test_late_response();
        test_freeze_off();
        test_fast();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule